// File: doc/BRIEF.md
# Test Vector Force/Compare Engine

This block plays a stored list of test vectors against a device, one vector for each tester cycle. Each vector holds force data, expected data, a compare mask and a template number. The template gives every group of channels one role for that cycle: drive, check or ignore. While a vector is applied, the engine puts the force data on the channel drive lines. It enables the drivers of the drive-role channels only while the timing generator holds the force window open. When the compare strobe arrives, it latches the device responses once and checks the latched value against the expected data, leaving out masked channels.

Vectors and templates are loaded through simple write ports before a run. A start pulse plays the vectors from 0 up to a programmed last index. Afterwards the engine shows a done flag, a sticky run-fail flag and a sticky per-channel fail vector. A small log keeps the index and failing-channel set of the first failing vectors, in the order they failed.

The controller has five states. IDLE waits for start. LOAD reads the next vector from the store. APPLY presents the vector and waits for the compare strobe. CHECK evaluates the latched response and logs any failure. DONE holds the result. Transitions: IDLE→LOAD on start; LOAD→APPLY always; APPLY→CHECK on strobe; CHECK→LOAD when vectors remain; CHECK→DONE after the last index; DONE→LOAD on start.

Top module: `tvec_engine`

## Requirements
- R1: After reset, done, run_fail, busy, vec_live, chan_oe, chan_drv, chan_fail_acc and log_count are all zero.
- R2: A template holds a 2-bit role code for each channel group; group g covers channels g*GW to g*GW+GW-1 (GW = NCH/NGRP), and its code sits in bits [2g+1:2g] of the template word. Code 2'b01 means drive, 2'b10 means compare, and 2'b00 or 2'b11 means ignore. A channel is never both driven and compared.
- R3: chan_oe is high only for drive-role channels of the applied vector, and only while vec_live and force_win are both high. chan_drv carries the vector's force data while vec_live is high and zero otherwise.
- R4: Device responses are latched only in a cycle with vec_live and cmp_strobe both high. The check uses that latched value, not the value on chan_in before or after it.
- R5: A channel fails a vector when its role is compare, its mask bit is 0, and the latched response differs from the expected bit. Masked, drive-role and ignore-role channels never fail.
- R6: A start accepted in IDLE or DONE plays vectors 0 through last_idx in order, each under its own template. done then rises and stays high until the next start.
- R7: run_fail is set when any vector fails and stays set until the next accepted start clears it. chan_fail_acc is the OR of all per-vector channel fail sets in the run, and a start also clears it.
- R8: The error log records the vector index and the failing-channel mask of the first LOG_N failing vectors in order, readable by log_raddr. log_count counts these entries and saturates at LOG_N.
- R9: A start pulse while busy is ignored and does not restart the vector sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_we | input | 1 | Vector store write enable |
| vec_waddr | input | AW | Vector store write address |
| vec_force | input | NCH | Force data to store |
| vec_exp | input | NCH | Expected data to store |
| vec_mask | input | NCH | Compare mask to store (1 = excluded) |
| vec_tpl | input | TW | Template number to store |
| tpl_we | input | 1 | Template write enable |
| tpl_waddr | input | TW | Template write address |
| tpl_roles | input | 2*NGRP | Per-group role codes |
| last_idx | input | AW | Index of the final vector in a run |
| start | input | 1 | Begin a run |
| force_win | input | 1 | Force window from the timing generator |
| cmp_strobe | input | 1 | Compare strobe from the timing generator |
| chan_in | input | NCH | Device responses |
| chan_drv | output | NCH | Drive values toward the device |
| chan_oe | output | NCH | Driver enables |
| vec_live | output | 1 | A vector is applied (APPLY state) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished |
| run_fail | output | 1 | Sticky run failure |
| chan_fail_acc | output | NCH | Sticky per-channel failures |
| log_count | output | LW | Number of logged failing vectors |
| log_raddr | input | LOGAW | Error log read address |
| log_vidx | output | AW | Logged vector index |
| log_chmask | output | NCH | Logged failing-channel mask |

## Verification
The compare path is exercised with a response that matches every expectation, and then with a mixed run. In the mixed run a mask hides some mismatches and a mixed template leaves drive and ignore groups out of the check, so only the unmasked compare-group bits may show as failures. A strobe test changes chan_in just before and just after the strobe, which tells capture at the strobe apart from capture at any other moment. A run in which every vector fails fills the log past its depth, and a stalled run receives a stray start. Together these separate saturation and ignored-start behaviour from restart behaviour.

// File: rtl/tvec_pkg.sv
package tvec_pkg;
    typedef enum logic [1:0] {
        ROLE_NONE  = 2'b00,
        ROLE_DRIVE = 2'b01,
        ROLE_CHECK = 2'b10,
        ROLE_SKIP  = 2'b11
    } role_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LOAD  = 3'd1,
        S_APPLY = 3'd2,
        S_CHECK = 3'd3,
        S_DONE  = 3'd4
    } eng_state_t;
endpackage

// File: rtl/tvec_store.sv
module tvec_store #(
    parameter int NCH   = 16,
    parameter int NGRP  = 4,
    parameter int NTPL  = 4,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int TW   = $clog2(NTPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [NCH-1:0]    wforce,
    input  logic [NCH-1:0]    wexp,
    input  logic [NCH-1:0]    wmask,
    input  logic [TW-1:0]     wtpl,
    input  logic              tpl_we,
    input  logic [TW-1:0]     tpl_waddr,
    input  logic [2*NGRP-1:0] tpl_wroles,
    input  logic              rd_en,
    input  logic [AW-1:0]     raddr,
    output logic [NCH-1:0]    q_force,
    output logic [NCH-1:0]    q_exp,
    output logic [NCH-1:0]    q_mask,
    output logic [2*NGRP-1:0] q_roles
);
    logic [NCH-1:0]    mem_force [DEPTH];
    logic [NCH-1:0]    mem_exp   [DEPTH];
    logic [NCH-1:0]    mem_mask  [DEPTH];
    logic [TW-1:0]     mem_tpl   [DEPTH];
    logic [2*NGRP-1:0] tpl_tab   [NTPL];
    logic [TW-1:0]     q_tpl;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_force[waddr] <= wforce;
            mem_exp[waddr]   <= wexp;
            mem_mask[waddr]  <= wmask;
            mem_tpl[waddr]   <= wtpl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NTPL; t++) tpl_tab[t] <= '0;
        end else if (tpl_we) begin
            tpl_tab[tpl_waddr] <= tpl_wroles;
        end
    end

    // Read data holds between reads so the applied vector stays stable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_force <= '0;
            q_exp   <= '0;
            q_mask  <= '0;
            q_tpl   <= '0;
        end else if (rd_en) begin
            q_force <= mem_force[raddr];
            q_exp   <= mem_exp[raddr];
            q_mask  <= mem_mask[raddr];
            q_tpl   <= mem_tpl[raddr];
        end
    end

    assign q_roles = tpl_tab[q_tpl];
endmodule

// File: rtl/tvec_role_decode.sv
module tvec_role_decode
    import tvec_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NGRP = 4,
    localparam int GW  = NCH / NGRP
) (
    input  logic [2*NGRP-1:0] roles,
    output logic [NCH-1:0]    drive_en,
    output logic [NCH-1:0]    check_en
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        role_t grp_role;
        assign grp_role = role_t'(roles[2*g +: 2]);
        for (genvar c = 0; c < GW; c++) begin : g_ch
            assign drive_en[g*GW + c] = (grp_role == ROLE_DRIVE);
            assign check_en[g*GW + c] = (grp_role == ROLE_CHECK);
        end
    end
endmodule

// File: rtl/tvec_compare.sv
module tvec_compare #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic [NCH-1:0] chan_in,
    input  logic [NCH-1:0] exp_d,
    input  logic [NCH-1:0] mask_d,
    input  logic [NCH-1:0] check_en,
    output logic [NCH-1:0] fail_vec
);
    logic [NCH-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cap_q <= '0;
        else if (cap_en) cap_q <= chan_in;
    end

    assign fail_vec = check_en & ~mask_d & (cap_q ^ exp_d);

    // R4
    cap_only_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(cap_q))
        else $error("capture register changed without strobe");
endmodule

// File: rtl/tvec_errlog.sv
module tvec_errlog #(
    parameter int NCH   = 16,
    parameter int AW    = 6,
    parameter int LOG_N = 16,
    localparam int LOGAW = $clog2(LOG_N),
    localparam int LW    = $clog2(LOG_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [AW-1:0]    widx,
    input  logic [NCH-1:0]   wmask,
    output logic [LW-1:0]    count,
    input  logic [LOGAW-1:0] raddr,
    output logic [AW-1:0]    rd_idx,
    output logic [NCH-1:0]   rd_mask
);
    logic [AW-1:0]  ent_idx  [LOG_N];
    logic [NCH-1:0] ent_mask [LOG_N];
    logic           room;

    assign room = (count < LW'(LOG_N));

    always_ff @(posedge clk) begin
        if (we && room && !clr) begin
            ent_idx[count[LOGAW-1:0]]  <= widx;
            ent_mask[count[LOGAW-1:0]] <= wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          count <= '0;
        else if (clr)        count <= '0;
        else if (we && room) count <= count + 1'b1;
    end

    assign rd_idx  = ent_idx[raddr];
    assign rd_mask = ent_mask[raddr];

    // R8
    log_count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LW'(LOG_N))
        else $error("error log count above depth");
endmodule

// File: rtl/tvec_engine.sv
module tvec_engine
    import tvec_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NGRP  = 4,
    parameter int NTPL  = 4,
    parameter int DEPTH = 64,
    parameter int LOG_N = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int TW    = $clog2(NTPL),
    localparam int LOGAW = $clog2(LOG_N),
    localparam int LW    = $clog2(LOG_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_we,
    input  logic [AW-1:0]     vec_waddr,
    input  logic [NCH-1:0]    vec_force,
    input  logic [NCH-1:0]    vec_exp,
    input  logic [NCH-1:0]    vec_mask,
    input  logic [TW-1:0]     vec_tpl,
    input  logic              tpl_we,
    input  logic [TW-1:0]     tpl_waddr,
    input  logic [2*NGRP-1:0] tpl_roles,
    input  logic [AW-1:0]     last_idx,
    input  logic              start,
    input  logic              force_win,
    input  logic              cmp_strobe,
    input  logic [NCH-1:0]    chan_in,
    output logic [NCH-1:0]    chan_drv,
    output logic [NCH-1:0]    chan_oe,
    output logic              vec_live,
    output logic              busy,
    output logic              done,
    output logic              run_fail,
    output logic [NCH-1:0]    chan_fail_acc,
    output logic [LW-1:0]     log_count,
    input  logic [LOGAW-1:0]  log_raddr,
    output logic [AW-1:0]     log_vidx,
    output logic [NCH-1:0]    log_chmask
);
    eng_state_t        state_q, state_d;
    logic [AW-1:0]     idx_q;
    logic [NCH-1:0]    cur_force, cur_exp, cur_mask;
    logic [2*NGRP-1:0] cur_roles;
    logic [NCH-1:0]    drive_en, check_en, fail_vec;
    logic              rd_en, cap_en, log_we, run_go, at_last, vec_bad;

    tvec_store #(.NCH(NCH), .NGRP(NGRP), .NTPL(NTPL), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(vec_we), .waddr(vec_waddr), .wforce(vec_force), .wexp(vec_exp),
        .wmask(vec_mask), .wtpl(vec_tpl),
        .tpl_we(tpl_we), .tpl_waddr(tpl_waddr), .tpl_wroles(tpl_roles),
        .rd_en(rd_en), .raddr(idx_q),
        .q_force(cur_force), .q_exp(cur_exp), .q_mask(cur_mask), .q_roles(cur_roles)
    );

    tvec_role_decode #(.NCH(NCH), .NGRP(NGRP)) u_roles (
        .roles(cur_roles), .drive_en(drive_en), .check_en(check_en)
    );

    tvec_compare #(.NCH(NCH)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .chan_in(chan_in),
        .exp_d(cur_exp), .mask_d(cur_mask), .check_en(check_en), .fail_vec(fail_vec)
    );

    tvec_errlog #(.NCH(NCH), .AW(AW), .LOG_N(LOG_N)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(run_go), .we(log_we),
        .widx(idx_q), .wmask(fail_vec), .count(log_count),
        .raddr(log_raddr), .rd_idx(log_vidx), .rd_mask(log_chmask)
    );

    assign at_last = (idx_q == last_idx);
    assign vec_bad = |fail_vec;
    assign run_go  = start && ((state_q == S_IDLE) || (state_q == S_DONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_LOAD;
            S_LOAD:  state_d = S_APPLY;
            S_APPLY: if (cmp_strobe) state_d = S_CHECK;
            S_CHECK: state_d = at_last ? S_DONE : S_LOAD;
            S_DONE:  if (start) state_d = S_LOAD;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        vec_live = (state_q == S_APPLY);
        busy     = (state_q == S_LOAD) || (state_q == S_APPLY) || (state_q == S_CHECK);
        done     = (state_q == S_DONE);
        rd_en    = (state_q == S_LOAD);
        cap_en   = (state_q == S_APPLY) && cmp_strobe;
        log_we   = (state_q == S_CHECK) && vec_bad;
        chan_drv = vec_live ? cur_force : '0;
        chan_oe  = drive_en & {NCH{vec_live && force_win}};
    end

    // Vector index and run results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q         <= '0;
            run_fail      <= 1'b0;
            chan_fail_acc <= '0;
        end else if (run_go) begin
            idx_q         <= '0;
            run_fail      <= 1'b0;
            chan_fail_acc <= '0;
        end else if (state_q == S_CHECK) begin
            if (!at_last) idx_q <= idx_q + 1'b1;
            if (vec_bad)  run_fail <= 1'b1;
            chan_fail_acc <= chan_fail_acc | fail_vec;
        end
    end

    // R3
    oe_only_when_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_oe) |-> ($past(state_q) == S_LOAD || $past(state_q) == S_APPLY))
        else $error("drivers enabled outside an applied vector");

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done)
        else $error("done dropped without a start");

    // R7
    run_fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_fail && !start) |=> run_fail)
        else $error("run_fail cleared without a start");

    // R9
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state_q == S_APPLY)) |=> !$fell(busy))
        else $error("start while busy disturbed the run");
endmodule

// File: tb/tb_tvec_engine.sv
module tb_tvec_engine;
    localparam int CLK_P = 10;
    localparam int NCH = 16, NGRP = 4, NTPL = 4, DEPTH = 64, LOG_N = 16;
    localparam int AW = $clog2(DEPTH), TW = $clog2(NTPL);
    localparam int LOGAW = $clog2(LOG_N), LW = $clog2(LOG_N + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic vec_we = 0, tpl_we = 0, start = 0, force_win = 0, cmp_strobe = 0;
    logic [AW-1:0] vec_waddr = '0, last_idx = '0;
    logic [NCH-1:0] vec_force = '0, vec_exp = '0, vec_mask = '0, chan_in = '0;
    logic [TW-1:0] vec_tpl = '0, tpl_waddr = '0;
    logic [2*NGRP-1:0] tpl_roles = '0;
    logic [LOGAW-1:0] log_raddr = '0;
    logic [NCH-1:0] chan_drv, chan_oe, chan_fail_acc, log_chmask;
    logic vec_live, busy, done, run_fail;
    logic [LW-1:0] log_count;
    logic [AW-1:0] log_vidx;
    int n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    tvec_engine #(.NCH(NCH), .NGRP(NGRP), .NTPL(NTPL), .DEPTH(DEPTH), .LOG_N(LOG_N)) dut (
        .clk(clk), .rst_n(rst_n), .vec_we(vec_we), .vec_waddr(vec_waddr),
        .vec_force(vec_force), .vec_exp(vec_exp), .vec_mask(vec_mask), .vec_tpl(vec_tpl),
        .tpl_we(tpl_we), .tpl_waddr(tpl_waddr), .tpl_roles(tpl_roles), .last_idx(last_idx),
        .start(start), .force_win(force_win), .cmp_strobe(cmp_strobe), .chan_in(chan_in),
        .chan_drv(chan_drv), .chan_oe(chan_oe), .vec_live(vec_live), .busy(busy),
        .done(done), .run_fail(run_fail), .chan_fail_acc(chan_fail_acc),
        .log_count(log_count), .log_raddr(log_raddr), .log_vidx(log_vidx),
        .log_chmask(log_chmask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_tpl(input int a, input logic [2*NGRP-1:0] r);
        @(negedge clk);
        tpl_we = 1; tpl_waddr = TW'(a); tpl_roles = r;
        @(negedge clk);
        tpl_we = 0;
    endtask

    task automatic wr_vec(input int a, input logic [NCH-1:0] f, input logic [NCH-1:0] e,
                          input logic [NCH-1:0] m, input int t);
        @(negedge clk);
        vec_we = 1; vec_waddr = AW'(a); vec_force = f; vec_exp = e; vec_mask = m;
        vec_tpl = TW'(t);
        @(negedge clk);
        vec_we = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic pulse_strobe();
        @(negedge clk); cmp_strobe = 1;
        @(negedge clk); cmp_strobe = 0;
    endtask

    task automatic wait_live();
        while (!vec_live) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic rd_log(input int a);
        log_raddr = LOGAW'(a);
        #1;
    endtask

    // Templates: 0 all compare, 1 all drive, 2 g0 drive/g1 compare/g2 code 00/g3 code 11,
    // 3 g0 compare only.
    task automatic load_templates();
        wr_tpl(0, 8'b10_10_10_10);
        wr_tpl(1, 8'b01_01_01_01);
        wr_tpl(2, 8'b11_00_10_01);
        wr_tpl(3, 8'b00_00_00_10);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 done", done, 0);
        chk("R1 run_fail", run_fail, 0);
        chk("R1 busy", busy, 0);
        chk("R1 vec_live", vec_live, 0);
        chk("R1 chan_oe", chan_oe, 0);
        chk("R1 chan_drv", chan_drv, 0);
        chk("R1 acc", chan_fail_acc, 0);
        chk("R1 log_count", log_count, 0);
    endtask

    task automatic t_all_pass();
        for (int i = 0; i < 4; i++) wr_vec(i, 16'h0, 16'hC3A5, 16'h0, 0);
        last_idx = AW'(3); chan_in = 16'hC3A5; cmp_strobe = 1;
        pulse_start();
        wait_done();
        cmp_strobe = 0; #1;
        chk("R6 done after pass run", done, 1);
        chk("R5 no fail on match", run_fail, 0);
        chk("R7 acc clean", chan_fail_acc, 0);
        chk("R8 empty log", log_count, 0);
        repeat (3) @(negedge clk);
        chk("R6 done holds", done, 1);
    endtask

    task automatic t_mask_roles();
        wr_vec(0, 16'h0, 16'h0F0F, 16'h000F, 0);
        wr_vec(1, 16'h0, 16'hFFFF, 16'h0000, 2);
        wr_vec(2, 16'hFFFF, 16'h0000, 16'h0000, 3);
        last_idx = AW'(2); chan_in = 16'h0000; cmp_strobe = 1;
        pulse_start();
        wait_done();
        cmp_strobe = 0; #1;
        chk("R7 run_fail set", run_fail, 1);
        chk("R7 acc union", chan_fail_acc, 16'h0FF0);
        chk("R8 log_count", log_count, 2);
        rd_log(0);
        chk("R8 log0 idx", log_vidx, 0);
        chk("R5 mask hides bits 0-3", log_chmask, 16'h0F00);
        rd_log(1);
        chk("R8 log1 idx", log_vidx, 1);
        chk("R2 only g1 compared", log_chmask, 16'h00F0);
    endtask

    task automatic t_strobe();
        wr_vec(0, 16'h0, 16'h1234, 16'h0, 0);
        wr_vec(1, 16'h0, 16'h1234, 16'h0, 0);
        last_idx = AW'(1); chan_in = 16'hFFFF;
        pulse_start(); #1;
        chk("R7 run_fail cleared at start", run_fail, 0);
        chk("R6 done cleared at start", done, 0);
        chk("R8 log cleared at start", log_count, 0);
        wait_live();
        repeat (2) @(negedge clk);
        chan_in = 16'h1234;
        pulse_strobe();
        chan_in = 16'hFFFF;
        wait_live();
        chan_in = 16'h1235;
        pulse_strobe();
        chan_in = 16'h1234;
        wait_done(); #1;
        chk("R4 run_fail from strobe value", run_fail, 1);
        chk("R4 one failing vector", log_count, 1);
        rd_log(0);
        chk("R4 failing index", log_vidx, 1);
        chk("R4 failing bit", log_chmask, 16'h0001);
    endtask

    task automatic t_force();
        wr_vec(0, 16'hA5A5, 16'h0, 16'h0, 2);
        wr_vec(1, 16'h5A5A, 16'h0, 16'h0, 1);
        last_idx = AW'(1); chan_in = 16'h0; force_win = 0;
        #1;
        chk("R3 drv zero when idle", chan_drv, 0);
        pulse_start();
        wait_live(); #1;
        chk("R3 oe low outside window", chan_oe, 0);
        chk("R3 drive data", chan_drv, 16'hA5A5);
        force_win = 1; #1;
        chk("R3 oe only g0", chan_oe, 16'h000F);
        pulse_strobe(); #1;
        chk("R3 oe low after strobe", chan_oe, 0);
        wait_live(); #1;
        chk("R3 oe all drive", chan_oe, 16'hFFFF);
        chk("R6 second vector data", chan_drv, 16'h5A5A);
        pulse_strobe();
        force_win = 0;
        wait_done(); #1;
        chk("R5 drive channels never fail", run_fail, 0);
    endtask

    task automatic t_log_sat();
        for (int i = 0; i < 20; i++) wr_vec(i, 16'h0, 16'hFFFF, 16'h0, 0);
        last_idx = AW'(19); chan_in = 16'h0; cmp_strobe = 1;
        pulse_start();
        wait_done();
        cmp_strobe = 0; #1;
        chk("R8 log saturates", log_count, LOG_N);
        rd_log(0);
        chk("R8 first entry idx", log_vidx, 0);
        rd_log(15);
        chk("R8 last entry idx", log_vidx, 15);
        chk("R8 last entry mask", log_chmask, 16'hFFFF);
        chk("R7 acc all", chan_fail_acc, 16'hFFFF);
    endtask

    task automatic t_busy_start();
        wr_vec(0, 16'h0, 16'h0, 16'h0, 3);
        wr_vec(1, 16'h0, 16'h0, 16'h0, 3);
        last_idx = AW'(1); chan_in = 16'h0;
        pulse_start();
        wait_live();
        pulse_start(); #1;
        chk("R9 still applying", vec_live, 1);
        pulse_strobe();
        wait_live();
        pulse_strobe();
        @(negedge clk); #1;
        chk("R9 run not restarted", done, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        load_templates();
        t_all_pass();
        t_mask_roles();
        t_strobe();
        t_force();
        t_log_sat();
        t_busy_start();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule